// File: doc/BRIEF.md
# Handshaked Indexed Parameter Loader

This block lets a host load configuration parameters into fabric memory one word at a time. The host sees three registers: a parameter value, a target index and a one-bit pending flag. The host fills in the value and the index, then sets the flag. On the next clock the block stores the value at that index in a parameter memory and drops the flag in the same cycle. The dropped flag is the host's acknowledgment. The host waits for it before it sends the next parameter. Parameters may arrive in any index order.

Computation logic reads the parameter memory through its own port, addressed freely and with one cycle of latency. The memory has exactly one write site, the loader, and one read site. Because of this, no arbitration between the two is needed.

Top module: `param_loader`

## Requirements
- R1: After synchronous reset the pending flag reads 0, and the value and index registers read 0.
- R2: Host register addresses are 0 for value, 1 for index and 2 for flag. A read of address 1 returns the low 6 index bits zero-extended. A read of address 2 returns the flag in bit 0 with zeros above it. A read of address 3 returns 0.
- R3: Only a host write to address 2 with bit 0 equal to 1 sets the flag. A write with bit 0 equal to 0 leaves a clear flag clear.
- R4: When the flag is set, the next clock edge writes the value into memory at the index and clears the flag on that same edge, so the flag is high for exactly one cycle.
- R5: Index bits above bit 5 are ignored. An index of 0x47 targets entry 7.
- R6: Entries may be loaded in any index order, and each entry keeps its value until it is loaded again.
- R7: The read port has one cycle of latency. Data for the address presented before a clock edge is valid after that edge.
- R8: A read and a write to the same address on the same edge return the old contents.
- R9: A host set of the flag on the same edge that the block clears it has no effect. The flag ends clear and only one memory write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hst_we | input | 1 | Host register write strobe |
| hst_addr | input | 2 | Host register select |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host register readback |
| rd_addr | input | 6 | Parameter read address |
| rd_data | output | 32 | Parameter read data, one cycle after the address |

## Verification
On every cycle, the assertions check the flag's protocol. The flag rises only on a host set, it stays high for a single cycle, and it stays clear while no set arrives. They also check that each pending parameter lands at its masked index. Readback encoding, index masking, out-of-order loading, read latency, and old-data return on a same-address collision are only shown by the bench's scenarios, which compare the port values against expected contents.

// File: rtl/param_loader.sv
module param_loader #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_we,
  input  logic [1:0]        hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [1:0] A_VAL = 2'd0, A_IDX = 2'd1, A_FLG = 2'd2;

  logic [DATA_W-1:0] val_q;
  logic [IDX_W-1:0]  idx_q;
  logic              flag_q;
  logic [DATA_W-1:0] mem [DEPTH];

  wire host_set = hst_we && hst_addr == A_FLG && hst_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '0;
      idx_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (hst_we && hst_addr == A_VAL) val_q <= hst_wdata;
      if (hst_we && hst_addr == A_IDX) idx_q <= hst_wdata[IDX_W-1:0];
      if (flag_q)        flag_q <= 1'b0;
      else if (host_set) flag_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (flag_q) mem[idx_q] <= val_q;
    rd_data <= mem[rd_addr];
  end

  always_comb begin
    case (hst_addr)
      A_VAL:   hst_rdata = val_q;
      A_IDX:   hst_rdata = DATA_W'(idx_q);
      A_FLG:   hst_rdata = DATA_W'(flag_q);
      default: hst_rdata = '0;
    endcase
  end

  // R3
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(hst_we && hst_addr == A_FLG && hst_wdata[0]));
  // R4
  flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q |=> !flag_q);
  // R3
  flag_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !host_set) |=> !flag_q);
  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    flag_q |=> mem[$past(idx_q)] == $past(val_q));
endmodule

// File: tb/param_loader_tb.sv
module param_loader_tb;
  logic clk = 0, rst = 1, hst_we = 0;
  logic [1:0] hst_addr = 0;
  logic [31:0] hst_wdata = 0, hst_rdata, rd_data;
  logic [5:0] rd_addr = 0;
  int n_run = 0, n_fail = 0;

  param_loader u_dut (.clk, .rst, .hst_we, .hst_addr, .hst_wdata, .hst_rdata, .rd_addr, .rd_data);

  always #4 clk = ~clk;

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); hst_we = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_we = 0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [31:0] d);
    hst_addr = a; #1 d = hst_rdata;
  endtask

  task automatic load(input logic [31:0] idx, input logic [31:0] v);
    logic [31:0] f;
    hwrite(0, v); hwrite(1, idx); hwrite(2, 1);
    hread(2, f);
    while (f[0]) begin @(negedge clk); hread(2, f); end
  endtask

  task automatic pread(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    hread(0, d); check("R1 value", d, 0);
    hread(1, d); check("R1 index", d, 0);
    hread(2, d); check("R1 flag", d, 0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    hwrite(0, 32'hCAFE_F00D); hread(0, d); check("R2 value", d, 32'hCAFE_F00D);
    hwrite(1, 32'hFFFF_FFEA); hread(1, d); check("R2 index", d, 32'h2A);
    hread(3, d); check("R2 addr3", d, 0);
    hwrite(2, 32'hFFFF_FFFE); hread(2, d); check("R3 clear write", d, 0);
  endtask

  task automatic t_handshake;
    logic [31:0] d;
    hwrite(0, 32'h1111_2222); hwrite(1, 3);
    @(negedge clk); hst_we = 1; hst_addr = 2; hst_wdata = 1;
    @(negedge clk); hst_we = 0; hread(2, d); check("R4 flag set", d, 1);
    @(negedge clk); hread(2, d); check("R4 flag cleared", d, 0);
    pread(3, d); check("R4 stored", d, 32'h1111_2222);
  endtask

  task automatic t_order;
    logic [31:0] d;
    load(40, 32'hA0); load(2, 32'hA1); load(63, 32'hA2); load(0, 32'hA3);
    pread(63, d); check("R6 e63", d, 32'hA2);
    pread(2, d);  check("R6 e2", d, 32'hA1);
    pread(40, d); check("R6 e40", d, 32'hA0);
    pread(0, d);  check("R6 e0", d, 32'hA3);
    load(32'h47, 32'h5555); pread(7, d); check("R5 masked", d, 32'h5555);
  endtask

  task automatic t_latency;
    logic [31:0] d;
    load(10, 32'hBEEF); load(11, 32'hD00D);
    @(negedge clk); rd_addr = 10;
    @(negedge clk); rd_addr = 11; check("R7 first", rd_data, 32'hBEEF);
    @(negedge clk); check("R7 second", rd_data, 32'hD00D);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    load(5, 32'h0000_00AA);
    hwrite(0, 32'h0000_00BB); hwrite(1, 5);
    @(negedge clk); hst_we = 1; hst_addr = 2; hst_wdata = 1;
    @(negedge clk); hst_we = 0; rd_addr = 5;
    @(negedge clk); check("R8 old data", rd_data, 32'hAA);
    @(negedge clk); check("R8 new data", rd_data, 32'hBB);
  endtask

  task automatic t_reset_again;
    logic [31:0] d;
    hwrite(0, 32'h0000_0777); hwrite(1, 9);
    @(negedge clk); hst_we = 1; hst_addr = 2; hst_wdata = 1;
    @(negedge clk); hst_wdata = 1;
    @(negedge clk); hst_we = 0; hread(2, d); check("R9 flag clear", d, 0);
    hwrite(0, 32'h0000_0888);
    repeat (2) @(negedge clk);
    pread(9, d); check("R9 single write", d, 32'h777);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_readback();
    t_handshake();
    t_order();
    t_latency();
    t_collide();
    t_reset_again();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule